// File: doc/BRIEF.md
# Debug Memory Access Port

This block is a bus master on the debug side of a chip. An external debug probe reaches it through a plain register read/write request interface. Through that interface the probe sets up a target address and a transfer size. It then moves data to or from system memory by touching a data register. Each touch of the data register issues exactly one transfer on a valid/ready memory bus. The processor keeps running, so the probe can inspect or patch memory while software executes.

A selection register picks which access port and which register bank later requests address. Only port 0, bank 0 exposes the memory-access registers. An auto-increment bit in the control word advances the target address by the transfer size after each launched transfer. With that bit set, a run of data-register accesses walks through consecutive memory as a burst. The bus side keeps one transfer in flight. A data access that arrives while a transfer is still open is refused with a wait status and is not queued. Bus error responses are latched in a sticky flag that the probe clears explicitly.

Top module: `dbg_mem_port`

## Requirements
- R1: After reset, no response or bus transfer is active. The selection register reads 0, the target address reads 0, and the control word reads 0x00000002 (word size, auto-increment off, no error).
- R2: Requests to the selection, control and target-address registers (request register codes 0, 1, 2) get `rsp_status` 0 (OK) with `rsp_valid` one cycle after the request. A read returns the last written value. Only bits [2:0] (size), [7] (error) and [29] (auto-increment) of the control word are stored. Bit [6] reads the busy state and all other bits read 0.
- R3: When the selection register has a non-zero port field [31:24] or a non-zero bank field [7:4], accesses to codes 1, 2 and 3 return data 0 with OK status. Writes through them change nothing, and no bus transfer starts.
- R4: A write to the data register (code 3) raises `bus_valid` in the cycle after the request, with `bus_write`=1, the target address and the write data. These stay stable until `bus_ready`. The probe gets an OK response one cycle after the request.
- R5: A read of the data register starts one bus read at the target address. Its response arrives one cycle after the bus handshake and carries `bus_rdata`. The probe issues no new request while that response is outstanding.
- R6: With control bit [29] set, every launched transfer advances the target address by the transfer size. Writing 0x23000002 to the control word therefore gives word transfers at addresses +4 apart. With bit [29] clear, the address does not move.
- R7: Control size field [2:0] = 0, 1, 2 drives `bus_size` 0 (byte), 1 (halfword), 2 (word) and steps of 1, 2, 4 bytes. Codes 3 to 7 act as word (`bus_size` 2, step 4).
- R8: A data-register access made while a bus transfer is still open gets `rsp_status` 1 (WAIT). It launches nothing and leaves the target address unchanged. While a transfer is open, control bit [6] reads 1.
- R9: A bus error at a transfer handshake sets control bit [7]. The bit stays set until a control write with bit [7]=1. A data read that ends in error is answered with `rsp_status` 2 (FAULT) and data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Probe request strobe, one cycle per request |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_reg | input | 2 | Register code: 0 select, 1 control, 2 target address, 3 data |
| req_wdata | input | DATA_W | Register write data |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_status | output | 2 | 0 OK, 1 WAIT, 2 FAULT |
| rsp_rdata | output | DATA_W | Read data (0 for writes) |
| bus_valid | output | 1 | Memory transfer request |
| bus_write | output | 1 | Transfer direction |
| bus_addr | output | ADDR_W | Transfer address |
| bus_size | output | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata | output | DATA_W | Write data |
| bus_ready | input | 1 | Memory accepts/completes the transfer |
| bus_rdata | input | DATA_W | Memory read data, valid with bus_ready |
| bus_err | input | 1 | Memory error, valid with bus_ready |

## Verification
A register request and a data write are answered one cycle after the edge that samples them. A data read is answered one cycle after the edge on which `bus_valid` and `bus_ready` are both high, so its latency is the memory wait count plus one. A transfer is launched on the same edge that samples its request. The bench drives requests and memory responses on the falling clock edge and reads every response on the first falling edge after the registering edge. It counts the falling edges it waits and compares that count with the latency each requirement predicts. Memory-side results such as launched address, size, direction and transfer count are recorded by the bench's memory model at the handshake. They are checked once the probe response is back.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

  typedef enum logic [1:0] {
    REG_SEL   = 2'd0,
    REG_CTRL  = 2'd1,
    REG_TADDR = 2'd2,
    REG_DATA  = 2'd3
  } dmp_reg_e;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_WAIT  = 2'd1,
    ST_FAULT = 2'd2
  } dmp_status_e;

  // control word layout
  localparam int CTRL_SIZE_LSB = 0;
  localparam int CTRL_SIZE_W   = 3;
  localparam int CTRL_BUSY_BIT = 6;
  localparam int CTRL_ERR_BIT  = 7;
  localparam int CTRL_INC_BIT  = 29;

  // selection word layout
  localparam int SEL_BANK_LSB = 4;
  localparam int SEL_BANK_W   = 4;
  localparam int SEL_PORT_LSB = 24;
  localparam int SEL_PORT_W   = 8;

  localparam logic [CTRL_SIZE_W-1:0] SIZE_RESET = 3'd2;

  // map the stored size field onto the bus size code; unknown codes act as word
  function automatic logic [1:0] size_code(input logic [CTRL_SIZE_W-1:0] s);
    if (s > 3'd2) return 2'd2;
    return s[1:0];
  endfunction

endpackage

// File: rtl/dmp_rst_sync.sv
module dmp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/dmp_regs.sv
module dmp_regs
  import dmp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel_we,
  input  logic                   ctrl_we,
  input  logic                   taddr_we,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   adv,
  input  logic                   err_set,
  output logic [DATA_W-1:0]      sel_q,
  output logic [CTRL_SIZE_W-1:0] size_q,
  output logic                   inc_q,
  output logic                   err_q,
  output logic [ADDR_W-1:0]      taddr_q,
  output logic                   mem_bank
);

  logic [DATA_W-1:0]      sel_n;
  logic [CTRL_SIZE_W-1:0] size_n;
  logic                   inc_n;
  logic                   err_n;
  logic [ADDR_W-1:0]      taddr_n;
  logic [ADDR_W-1:0]      step;
  logic                   err_clr;
  logic                   taddr_en;

  // next state
  always_comb begin
    step     = ADDR_W'(1) << size_code(size_q);
    err_clr  = ctrl_we && wdata[CTRL_ERR_BIT];
    sel_n    = wdata;
    size_n   = wdata[CTRL_SIZE_LSB +: CTRL_SIZE_W];
    inc_n    = wdata[CTRL_INC_BIT];
    err_n    = err_set || (err_q && !err_clr);
    taddr_en = taddr_we || (adv && inc_q);
    if (taddr_we) taddr_n = wdata[ADDR_W-1:0];
    else          taddr_n = taddr_q + step;
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      size_q  <= SIZE_RESET;
      inc_q   <= 1'b0;
      err_q   <= 1'b0;
      taddr_q <= '0;
    end else begin
      if (sel_we)   sel_q   <= sel_n;
      if (ctrl_we)  size_q  <= size_n;
      if (ctrl_we)  inc_q   <= inc_n;
      err_q <= err_n;
      if (taddr_en) taddr_q <= taddr_n;
    end
  end

  assign mem_bank = (sel_q[SEL_PORT_LSB +: SEL_PORT_W] == '0) &&
                    (sel_q[SEL_BANK_LSB +: SEL_BANK_W] == '0);

  // R9: an error seen at a handshake is visible in the next cycle
  a_r9_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> err_q);

  // R9: the flag only drops on an explicit clear
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !(ctrl_we && wdata[CTRL_ERR_BIT]) |=> err_q);

  // R6: with auto-increment off a launch leaves the address alone
  a_r6_no_step_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !inc_q && !taddr_we |=> $stable(taddr_q));

endmodule

// File: rtl/dmp_bus_eng.sv
module dmp_bus_eng #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_write,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic [1:0]        start_size,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic              bus_err,
  output logic              busy,
  output logic              done,
  output logic              done_err
);

  logic act_q;
  logic act_n;

  always_comb begin
    act_n = act_q;
    if (act_q && bus_ready) act_n = 1'b0;
    if (start)              act_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_size  <= 2'd0;
      bus_wdata <= '0;
    end else begin
      act_q <= act_n;
      if (start) begin
        bus_write <= start_write;
        bus_addr  <= start_addr;
        bus_size  <= start_size;
        bus_wdata <= start_wdata;
      end
    end
  end

  assign bus_valid = act_q;
  assign busy      = act_q;
  assign done      = act_q && bus_ready;
  assign done_err  = bus_err;

  // R4: an open request holds its fields until accepted
  a_r4_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) &&
      $stable(bus_write) && $stable(bus_wdata) && $stable(bus_size));

  // R8: a new transfer never starts on top of an open one
  a_r8_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !act_q);

endmodule

// File: rtl/dbg_mem_port.sv
module dbg_mem_port
  import dmp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err
);

  logic rst_s;

  dmp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  // ---------------------------------------------------------------- decode
  dmp_reg_e               rsel;
  logic                   mem_bank;
  logic                   busy;
  logic                   done;
  logic                   done_err;
  logic                   is_data;
  logic                   launch;
  logic                   refuse;
  logic                   sel_we;
  logic                   ctrl_we;
  logic                   taddr_we;
  logic [DATA_W-1:0]      sel_q;
  logic [CTRL_SIZE_W-1:0] size_q;
  logic                   inc_q;
  logic                   err_q;
  logic [ADDR_W-1:0]      taddr_q;
  logic [DATA_W-1:0]      ctrl_word;
  logic [DATA_W-1:0]      reg_rdata;

  always_comb begin
    rsel     = dmp_reg_e'(req_reg);
    is_data  = req_valid && (rsel == REG_DATA) && mem_bank;
    launch   = is_data && !busy;
    refuse   = is_data && busy;
    sel_we   = req_valid && req_write && (rsel == REG_SEL);
    ctrl_we  = req_valid && req_write && (rsel == REG_CTRL)  && mem_bank;
    taddr_we = req_valid && req_write && (rsel == REG_TADDR) && mem_bank;
  end

  dmp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_s),
    .sel_we   (sel_we),
    .ctrl_we  (ctrl_we),
    .taddr_we (taddr_we),
    .wdata    (req_wdata),
    .adv      (launch),
    .err_set  (done && done_err),
    .sel_q    (sel_q),
    .size_q   (size_q),
    .inc_q    (inc_q),
    .err_q    (err_q),
    .taddr_q  (taddr_q),
    .mem_bank (mem_bank)
  );

  dmp_bus_eng #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk         (clk),
    .rst_n       (rst_s),
    .start       (launch),
    .start_write (req_write),
    .start_addr  (taddr_q),
    .start_wdata (req_wdata),
    .start_size  (size_code(size_q)),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_size    (bus_size),
    .bus_wdata   (bus_wdata),
    .bus_ready   (bus_ready),
    .bus_err     (bus_err),
    .busy        (busy),
    .done        (done),
    .done_err    (done_err)
  );

  // ---------------------------------------------------------- read mux
  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_SIZE_LSB +: CTRL_SIZE_W] = size_q;
    ctrl_word[CTRL_BUSY_BIT] = busy;
    ctrl_word[CTRL_ERR_BIT]  = err_q;
    ctrl_word[CTRL_INC_BIT]  = inc_q;
    reg_rdata = '0;
    case (rsel)
      REG_SEL:   reg_rdata = sel_q;
      REG_CTRL:  if (mem_bank) reg_rdata = ctrl_word;
      REG_TADDR: if (mem_bank) reg_rdata = DATA_W'(taddr_q);
      default:   reg_rdata = '0;
    endcase
  end

  // ------------------------------------------------------------ response
  logic              rsp_v_n;
  logic [1:0]        rsp_st_n;
  logic [DATA_W-1:0] rsp_rd_n;

  always_comb begin
    rsp_v_n  = 1'b0;
    rsp_st_n = ST_OK;
    rsp_rd_n = '0;
    if (done && !bus_write) begin
      rsp_v_n  = 1'b1;
      rsp_st_n = done_err ? ST_FAULT : ST_OK;
      rsp_rd_n = done_err ? '0 : bus_rdata;
    end else if (req_valid && !(launch && !req_write)) begin
      rsp_v_n  = 1'b1;
      rsp_st_n = refuse ? ST_WAIT : ST_OK;
      rsp_rd_n = (req_write || refuse) ? '0 : reg_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= rsp_v_n;
      if (rsp_v_n) begin
        rsp_status <= rsp_st_n;
        rsp_rdata  <= rsp_rd_n;
      end
    end
  end

  // R2: register requests answer OK on the next cycle
  a_r2_reg_response: assert property (@(posedge clk) disable iff (!rst_s)
    req_valid && (req_reg != 2'd3) |=> rsp_valid && (rsp_status == 2'd0));

  // R3: outside the memory bank nothing reaches the bus
  a_r3_no_bus_outside_bank: assert property (@(posedge clk) disable iff (!rst_s)
    req_valid && !mem_bank && !bus_valid |=> !bus_valid);

  // R5: the probe waits for an outstanding read result
  a_r5_probe_waits: assert property (@(posedge clk) disable iff (!rst_s)
    bus_valid && !bus_write |-> !req_valid);

  // R5: each response is a single-cycle strobe
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_s)
    rsp_valid |=> !rsp_valid);

  // R8: refused data accesses answer WAIT and start nothing new
  a_r8_wait_response: assert property (@(posedge clk) disable iff (!rst_s)
    req_valid && (req_reg == 2'd3) && mem_bank && bus_valid && !bus_ready
      |=> rsp_valid && (rsp_status == 2'd1) && $stable(bus_addr));

endmodule

// File: tb/dbg_mem_port_tb.sv
module dbg_mem_port_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [1:0]  req_reg;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_rdata;
  logic        bus_valid;
  logic        bus_write;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic        bus_err;

  dbg_mem_port u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_reg(req_reg),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ------------------------------------------------------ memory model
  logic [31:0] mem [64];
  int          bus_lat = 0;
  int          xfer_cnt = 0;
  logic [31:0] last_addr;
  logic        last_write;
  logic [31:0] last_wdata;
  logic [1:0]  last_size;

  initial begin
    bus_ready = 1'b0;
    bus_rdata = '0;
    bus_err   = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h5A000000 + i;
    begin : model
      int cnt = 0;
      forever begin
        @(negedge clk);
        if (bus_valid && cnt >= bus_lat) begin
          bus_ready  = 1'b1;
          bus_err    = (bus_addr[31:28] == 4'hE);
          bus_rdata  = (bus_addr < 32'h100) ? mem[bus_addr[7:2]] : ~bus_addr;
          if (bus_write && bus_addr < 32'h100) mem[bus_addr[7:2]] = bus_wdata;
          xfer_cnt++;
          last_addr  = bus_addr;
          last_write = bus_write;
          last_wdata = bus_wdata;
          last_size  = bus_size;
          cnt = 0;
        end else begin
          bus_ready = 1'b0;
          bus_err   = 1'b0;
          cnt = bus_valid ? cnt + 1 : 0;
        end
      end
    end
  end

  // ------------------------------------------------------ probe side
  task automatic probe(input logic wr, input logic [1:0] rg, input logic [31:0] wd,
                       output logic [1:0] st, output logic [31:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_reg = rg; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    st = rsp_valid ? rsp_status : 2'b11;
    rd = rsp_rdata;
  endtask

  task automatic wait_idle();
    while (bus_valid) @(negedge clk);
  endtask

  // table: [68] write, [67:66] reg, [65:34] wdata, [33:32] status, [31:0] rdata
  localparam int NV = 13;
  localparam logic [68:0] TBL [NV] = '{
    {1'b1, 2'd0, 32'h00000000, 2'd0, 32'h00000000},
    {1'b1, 2'd1, 32'h23000002, 2'd0, 32'h00000000},
    {1'b0, 2'd1, 32'h00000000, 2'd0, 32'h20000002},
    {1'b1, 2'd2, 32'h00000010, 2'd0, 32'h00000000},
    {1'b1, 2'd3, 32'h11111111, 2'd0, 32'h00000000},
    {1'b1, 2'd3, 32'h22222222, 2'd0, 32'h00000000},
    {1'b1, 2'd3, 32'h33333333, 2'd0, 32'h00000000},
    {1'b0, 2'd2, 32'h00000000, 2'd0, 32'h0000001C},
    {1'b1, 2'd2, 32'h00000010, 2'd0, 32'h00000000},
    {1'b0, 2'd3, 32'h00000000, 2'd0, 32'h11111111},
    {1'b0, 2'd3, 32'h00000000, 2'd0, 32'h22222222},
    {1'b0, 2'd3, 32'h00000000, 2'd0, 32'h33333333},
    {1'b0, 2'd2, 32'h00000000, 2'd0, 32'h0000001C}
  };

  initial begin
    logic [1:0]  st;
    logic [31:0] rd;
    int          lat;
    int          n0;
    req_valid = 1'b0; req_write = 1'b0; req_reg = 2'd0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 rsp_valid idle", 32'(rsp_valid), 32'd0);
    check("R1 bus_valid idle", 32'(bus_valid), 32'd0);
    probe(1'b0, 2'd0, 0, st, rd, lat); check("R1 select reset", rd, 32'h0);
    probe(1'b0, 2'd1, 0, st, rd, lat); check("R1 control reset", rd, 32'h00000002);
    probe(1'b0, 2'd2, 0, st, rd, lat); check("R1 address reset", rd, 32'h0);

    // table walk: R2 register access, R4/R5 data, R6 burst with 0x23000002
    for (int i = 0; i < NV; i++) begin
      probe(TBL[i][68], TBL[i][67:66], TBL[i][65:34], st, rd, lat);
      check($sformatf("R2/R6 table step %0d status", i), 32'(st), 32'(TBL[i][33:32]));
      if (!TBL[i][68])
        check($sformatf("R2/R6 table step %0d data", i), rd, TBL[i][31:0]);
      if (TBL[i][67:66] != 2'd3 || TBL[i][68])
        check($sformatf("R2 table step %0d latency", i), 32'(lat), 32'd0);
      wait_idle();
    end

    // R4: write launch with a slow memory
    bus_lat = 3;
    probe(1'b1, 2'd2, 32'h20, st, rd, lat);
    probe(1'b1, 2'd3, 32'hABCD0123, st, rd, lat);
    check("R4 write response latency", 32'(lat), 32'd0);
    check("R4 write response status", 32'(st), 32'd0);
    check("R4 request held open", 32'(bus_valid), 32'd1);
    check("R4 held address", bus_addr, 32'h20);
    wait_idle();
    @(negedge clk);
    check("R4 written address", last_addr, 32'h20);
    check("R4 written data", last_wdata, 32'hABCD0123);
    check("R4 direction", 32'(last_write), 32'd1);

    // R5: read latency is wait count plus one
    bus_lat = 2;
    probe(1'b1, 2'd2, 32'h20, st, rd, lat);
    probe(1'b0, 2'd3, 0, st, rd, lat);
    check("R5 read latency", 32'(lat), 32'd3);
    check("R5 read data", rd, 32'hABCD0123);

    // R8: refused access while a write is pending
    bus_lat = 5;
    probe(1'b1, 2'd2, 32'h30, st, rd, lat);
    n0 = xfer_cnt;
    probe(1'b1, 2'd3, 32'hCAFE0001, st, rd, lat);
    probe(1'b0, 2'd3, 0, st, rd, lat);
    check("R8 wait status", 32'(st), 32'd1);
    probe(1'b0, 2'd1, 0, st, rd, lat);
    check("R8 busy bit", rd, 32'h20000042);
    wait_idle();
    @(negedge clk);
    check("R8 single transfer", 32'(xfer_cnt - n0), 32'd1);
    probe(1'b0, 2'd2, 0, st, rd, lat);
    check("R8 address stepped once", rd, 32'h34);

    // R6: auto-increment off keeps the address
    bus_lat = 0;
    probe(1'b1, 2'd1, 32'h00000002, st, rd, lat);
    probe(1'b1, 2'd2, 32'h40, st, rd, lat);
    probe(1'b0, 2'd3, 0, st, rd, lat);
    probe(1'b0, 2'd2, 0, st, rd, lat);
    check("R6 no step when off", rd, 32'h40);

    // R7: size codes
    for (int s = 0; s < 8; s++) begin
      logic [1:0] code;
      code = (s > 2) ? 2'd2 : 2'(s);
      probe(1'b1, 2'd1, 32'h20000000 | 32'(s), st, rd, lat);
      probe(1'b1, 2'd2, 32'h40, st, rd, lat);
      probe(1'b0, 2'd3, 0, st, rd, lat);
      check($sformatf("R7 bus size for code %0d", s), 32'(last_size), 32'(code));
      probe(1'b0, 2'd2, 0, st, rd, lat);
      check($sformatf("R7 step for code %0d", s), rd, 32'h40 + (32'd1 << code));
    end

    // R9: error handling
    probe(1'b1, 2'd1, 32'h20000002, st, rd, lat);
    probe(1'b1, 2'd2, 32'hE0000004, st, rd, lat);
    probe(1'b0, 2'd3, 0, st, rd, lat);
    check("R9 fault status", 32'(st), 32'd2);
    check("R9 fault data", rd, 32'h0);
    probe(1'b0, 2'd1, 0, st, rd, lat);
    check("R9 flag set", rd, 32'h20000082);
    probe(1'b1, 2'd2, 32'h0, st, rd, lat);
    probe(1'b0, 2'd3, 0, st, rd, lat);
    probe(1'b1, 2'd1, 32'h20000002, st, rd, lat);
    probe(1'b0, 2'd1, 0, st, rd, lat);
    check("R9 flag survives good read and zero write", rd, 32'h20000082);
    probe(1'b1, 2'd1, 32'h20000082, st, rd, lat);
    probe(1'b0, 2'd1, 0, st, rd, lat);
    check("R9 flag cleared", rd, 32'h20000002);
    probe(1'b1, 2'd2, 32'hE0000100, st, rd, lat);
    probe(1'b1, 2'd3, 32'h1, st, rd, lat);
    check("R9 write answer before bus error", 32'(st), 32'd0);
    wait_idle();
    probe(1'b0, 2'd1, 0, st, rd, lat);
    check("R9 flag set by failed write", rd, 32'h20000082);
    probe(1'b1, 2'd1, 32'h20000082, st, rd, lat);

    // R3: other ports and banks
    probe(1'b1, 2'd2, 32'h50, st, rd, lat);
    probe(1'b1, 2'd0, 32'h01000000, st, rd, lat);
    probe(1'b0, 2'd0, 0, st, rd, lat);
    check("R2 select readback", rd, 32'h01000000);
    probe(1'b0, 2'd1, 0, st, rd, lat);
    check("R3 control hidden", rd, 32'h0);
    n0 = xfer_cnt;
    probe(1'b1, 2'd2, 32'h999, st, rd, lat);
    probe(1'b1, 2'd3, 32'h77, st, rd, lat);
    probe(1'b0, 2'd3, 0, st, rd, lat);
    check("R3 data read status", 32'(st), 32'd0);
    check("R3 data read zero", rd, 32'h0);
    probe(1'b1, 2'd0, 32'h00000010, st, rd, lat);
    probe(1'b1, 2'd1, 32'h00000001, st, rd, lat);
    probe(1'b0, 2'd2, 0, st, rd, lat);
    check("R3 address hidden in bank 1", rd, 32'h0);
    probe(1'b1, 2'd3, 32'h78, st, rd, lat);
    @(negedge clk);
    check("R3 no transfers", 32'(xfer_cnt - n0), 32'd0);
    probe(1'b1, 2'd0, 32'h0, st, rd, lat);
    probe(1'b0, 2'd2, 0, st, rd, lat);
    check("R3 address untouched", rd, 32'h50);
    probe(1'b0, 2'd1, 0, st, rd, lat);
    check("R3 control untouched", rd, 32'h20000002);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule